// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Pointer

This block keeps an 8-bit stack pointer and runs the accesses that the pointer drives into a 256-byte internal data RAM. The stack grows toward higher addresses. A push first moves the pointer up and then writes at the new address. A pop first reads at the current address and then moves the pointer down. After reset the pointer holds 0x07, so the first byte pushed lands at address 0x08.

A controller issues one strobe per operation: push a byte, pop a byte, save a 16-bit return address, restore a 16-bit return address, or load the pointer with a new value. The save command serves both subroutine calls and interrupt entry. Each byte transfer takes one clock. The save and restore commands each take two clocks, and the block raises busy during the second clock. The RAM port (address, write data, write enable) is driven at the block's boundary so it can be observed. The array itself is a simple internal model.

Top module: `stk_ptr_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, the pointer reads 0x07 and busy, pop_valid, ret_valid, illegal and ram_we are all low.
- R2: A byte push drives ram_we high in that same cycle, with ram_addr equal to the pointer plus one and ram_wdata equal to push_data. After the clock edge the pointer equals that address. The first push after reset writes address 0x08.
- R3: A byte pop reads RAM at the current pointer and then decrements the pointer. On the following cycle pop_valid is high for exactly one cycle, and pop_data holds the byte read.
- R4: A return-address save takes two cycles. The first cycle writes call_addr[7:0] at pointer+1. The second cycle, with busy high, writes call_addr[15:8] at pointer+2. The pointer ends two higher.
- R5: A return-address restore takes two cycles. It reads the high byte at the pointer first, then the low byte at pointer-1, with busy high during the second cycle. The pointer ends two lower. On the next cycle ret_valid pulses for one cycle, with ret_addr holding {high, low}.
- R6: A load strobe sets the pointer to load_val on the next edge and writes nothing.
- R7: The pointer wraps modulo 256 with no overflow indication: a push at 0xFF writes address 0x00, and a pop at 0x00 leaves 0xFF.
- R8: When more than one command strobe is high in a cycle where busy is low, illegal is high in that cycle. No write happens, and the pointer and all outputs behave as if no command had been given.
- R9: Command strobes present while busy is high are ignored. The second beat of the sequence in progress completes unchanged, and no extra write or pointer change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push one byte |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Save a 16-bit return address (call or interrupt entry) |
| call_addr | input | 16 | Return address to save |
| ret_req | input | 1 | Restore a 16-bit return address |
| load_req | input | 1 | Load the pointer directly |
| load_val | input | 8 | New pointer value |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Second beat of a two-byte sequence in progress |
| illegal | output | 1 | More than one command in an idle cycle |
| ram_addr | output | 8 | RAM address this cycle |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| pop_valid | output | 1 | pop_data holds a popped byte |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | ret_addr holds a restored address |
| ret_addr | output | 16 | Restored return address |

## Verification
The bench builds the block with its defaults: an 8-bit pointer, 8-bit data and a reset value of 0x07. With these values a single load of 0xFF reaches the wrap boundary, so both the increment and decrement wrap of R7 are tested directly, and a whole 256-byte address space can be tracked by the reference model. A long mixed run driven by a pseudo-random shift register puts save and restore commands back to back with stray strobes during busy cycles. It also produces command collisions, so the orderings of R4, R5, R8 and R9 are exercised together with the pointer arithmetic.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_LOAD = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CALLHI = 2'd1,
    PH_RETLO  = 2'd2
  } stk_phase_e;

  localparam int unsigned NUM_CMDS = 5;

  // Strobe index to operation, index order matches the command vector
  function automatic stk_op_e idx_to_op(input int unsigned idx);
    case (idx)
      0: return OP_PUSH;
      1: return OP_POP;
      2: return OP_CALL;
      3: return OP_RET;
      4: return OP_LOAD;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/stk_cmd_dec.sv
module stk_cmd_dec
  import stk_pkg::*;
(
  input  logic [NUM_CMDS-1:0] cmd_vec,
  input  logic                busy,
  output stk_op_e             op,
  output logic                illegal
);
  logic [$clog2(NUM_CMDS+1)-1:0] n_cmds;

  always_comb begin
    n_cmds = '0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      n_cmds = n_cmds + {{($clog2(NUM_CMDS+1)-1){1'b0}}, cmd_vec[i]};
    end
  end

  assign illegal = !busy && (n_cmds > 1);

  always_comb begin
    op = OP_NONE;
    if (!busy && n_cmds == 1) begin
      for (int i = 0; i < NUM_CMDS; i++) begin
        if (cmd_vec[i]) op = idx_to_op(i);
      end
    end
  end
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          PW      = 8,
  parameter int          DW      = 8,
  parameter logic [PW-1:0] RST_PTR = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stk_op_e         op,
  input  logic [DW-1:0]   push_data,
  input  logic [2*DW-1:0] call_addr,
  input  logic [PW-1:0]   load_val,
  input  logic [DW-1:0]   rd_data,
  output logic [PW-1:0]   sp,
  output logic [PW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic            busy,
  output logic            pop_fire,
  output logic            ret_fire,
  output logic            pop_valid,
  output logic [DW-1:0]   pop_data,
  output logic            ret_valid,
  output logic [2*DW-1:0] ret_addr
);
  function automatic logic [PW-1:0] ptr_up(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_down(input logic [PW-1:0] p);
    return p - PW'(1);
  endfunction

  stk_phase_e    phase, phase_n;
  logic [PW-1:0] sp_n;
  logic [DW-1:0] hold, hold_n;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    phase_n   = PH_IDLE;
    sp_n      = sp;
    hold_n    = hold;
    ram_addr  = sp;
    ram_wdata = '0;
    ram_we    = 1'b0;
    pop_fire  = 1'b0;
    ret_fire  = 1'b0;
    case (phase)
      PH_CALLHI: begin
        ram_addr  = ptr_up(sp);
        ram_wdata = hold;
        ram_we    = 1'b1;
        sp_n      = ptr_up(sp);
      end
      PH_RETLO: begin
        sp_n     = ptr_down(sp);
        ret_fire = 1'b1;
      end
      default: begin
        case (op)
          OP_PUSH: begin
            ram_addr  = ptr_up(sp);
            ram_wdata = push_data;
            ram_we    = 1'b1;
            sp_n      = ptr_up(sp);
          end
          OP_POP: begin
            sp_n     = ptr_down(sp);
            pop_fire = 1'b1;
          end
          OP_CALL: begin
            ram_addr  = ptr_up(sp);
            ram_wdata = call_addr[DW-1:0];
            ram_we    = 1'b1;
            sp_n      = ptr_up(sp);
            hold_n    = call_addr[2*DW-1:DW];
            phase_n   = PH_CALLHI;
          end
          OP_RET: begin
            sp_n    = ptr_down(sp);
            hold_n  = rd_data;
            phase_n = PH_RETLO;
          end
          OP_LOAD: sp_n = load_val;
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      sp        <= RST_PTR;
      hold      <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      ret_valid <= 1'b0;
      ret_addr  <= '0;
    end else begin
      phase     <= phase_n;
      sp        <= sp_n;
      hold      <= hold_n;
      pop_valid <= pop_fire;
      ret_valid <= ret_fire;
      if (pop_fire) pop_data <= rd_data;
      if (ret_fire) ret_addr <= {hold, rd_data};
    end
  end
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_pkg::*;
#(
  parameter int            PW      = 8,
  parameter int            DW      = 8,
  parameter logic [PW-1:0] RST_PTR = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_req,
  input  logic            call_req,
  input  logic [2*DW-1:0] call_addr,
  input  logic            ret_req,
  input  logic            load_req,
  input  logic [PW-1:0]   load_val,
  output logic [PW-1:0]   sp_out,
  output logic            busy,
  output logic            illegal,
  output logic [PW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic            pop_valid,
  output logic [DW-1:0]   pop_data,
  output logic            ret_valid,
  output logic [2*DW-1:0] ret_addr
);
  // Named internal events, brought out for the checker
  stk_op_e             cur_op;
  logic [NUM_CMDS-1:0] cmd_vec;
  logic [DW-1:0]       rd_data;
  logic                pop_fire;
  logic                ret_fire;

  assign cmd_vec = {load_req, ret_req, call_req, pop_req, push_req};

  stk_cmd_dec i_dec (
    .cmd_vec (cmd_vec),
    .busy    (busy),
    .op      (cur_op),
    .illegal (illegal)
  );

  stk_seq #(.PW(PW), .DW(DW), .RST_PTR(RST_PTR)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (cur_op),
    .push_data (push_data),
    .call_addr (call_addr),
    .load_val  (load_val),
    .rd_data   (rd_data),
    .sp        (sp_out),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .busy      (busy),
    .pop_fire  (pop_fire),
    .ret_fire  (ret_fire),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .ret_valid (ret_valid),
    .ret_addr  (ret_addr)
  );

  stk_ram #(.AW(PW), .DW(DW)) i_ram (
    .clk   (clk),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .we    (ram_we),
    .rdata (rd_data)
  );
endmodule

// File: rtl/stk_ptr_chk.sv
module stk_ptr_chk
  import stk_pkg::*;
#(
  parameter int            PW      = 8,
  parameter int            DW      = 8,
  parameter logic [PW-1:0] RST_PTR = 8'h07
) (
  input logic          clk,
  input logic          rst_n,
  input stk_op_e       cur_op,
  input logic          pop_fire,
  input logic          ret_fire,
  input logic [PW-1:0] sp_out,
  input logic [PW-1:0] load_val,
  input logic          busy,
  input logic          illegal,
  input logic [PW-1:0] ram_addr,
  input logic          ram_we,
  input logic          pop_valid,
  input logic          ret_valid
);
  assert_push_above_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_addr == PW'(sp_out + PW'(1)));

  assert_write_moves_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> sp_out == $past(ram_addr));

  assert_pop_reads_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_POP) |-> (ram_addr == sp_out && !ram_we));

  assert_pop_then_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (pop_valid && sp_out == PW'($past(sp_out) - PW'(1))));

  assert_call_second_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_CALL) |=> (busy && ram_we));

  assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_ret_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(busy));

  assert_ret_beat_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> (!ram_we && ram_addr == sp_out));

  assert_load_sets_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_LOAD) |=> sp_out == $past(load_val));

  assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!ram_we && cur_op == OP_NONE));

  assert_illegal_sp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(sp_out));

  assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_op == OP_NONE && !illegal));
endmodule

bind stk_ptr_unit stk_ptr_chk #(.PW(PW), .DW(DW), .RST_PTR(RST_PTR)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cur_op    (cur_op),
  .pop_fire  (pop_fire),
  .ret_fire  (ret_fire),
  .sp_out    (sp_out),
  .load_val  (load_val),
  .busy      (busy),
  .illegal   (illegal),
  .ram_addr  (ram_addr),
  .ram_we    (ram_we),
  .pop_valid (pop_valid),
  .ret_valid (ret_valid)
);

// File: tb/test_stk_ptr_unit.sv
`timescale 1ns/1ps
module test_stk_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0, load_req = 0;
  logic [7:0]  push_data = 0, load_val = 0;
  logic [15:0] call_addr = 0;
  logic [7:0]  sp_out, ram_addr, ram_wdata, pop_data;
  logic        busy, illegal, ram_we, pop_valid, ret_valid;
  logic [15:0] ret_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int        m_sp;
  int        m_phase;   // 0 idle, 1 second save beat, 2 second restore beat
  int        m_hold;
  bit [7:0]  m_mem [int];
  bit        e_pv, e_rv, e_pd_known, e_ra_known;
  int        e_pd, e_ra;
  bit        m_hold_known;

  always #4 clk = ~clk;  // 125 MHz

  stk_ptr_unit i_stk_ptr_unit (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .call_req(call_req), .call_addr(call_addr), .ret_req(ret_req),
    .load_req(load_req), .load_val(load_val),
    .sp_out(sp_out), .busy(busy), .illegal(illegal),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .pop_valid(pop_valid), .pop_data(pop_data),
    .ret_valid(ret_valid), .ret_addr(ret_addr)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit p, input bit [7:0] pd, input bit q, input bit c,
                       input bit [15:0] ca, input bit r, input bit l, input bit [7:0] lv);
    int  n;
    string tg;
    bit  x_we;
    int  x_a, x_d;
    int  nsp, nphase, nhold;
    bit  npv, nrv, npk, nrk, nhk;
    int  npd, nra;
    push_req = p; push_data = pd; pop_req = q; call_req = c; call_addr = ca;
    ret_req = r; load_req = l; load_val = lv;
    #1;
    n = p + q + c + r + l;
    x_we = 0; x_a = 0; x_d = 0;
    nsp = m_sp; nphase = 0; nhold = m_hold; nhk = m_hold_known;
    npv = 0; nrv = 0; npd = e_pd; nra = e_ra; npk = e_pd_known; nrk = e_ra_known;
    if (m_phase == 1) begin
      tg = (n > 0) ? "R9" : "R4";
      x_we = 1; x_a = (m_sp + 1) % 256; x_d = m_hold;
      m_mem[x_a] = x_d[7:0]; nsp = x_a;
    end else if (m_phase == 2) begin
      tg = (n > 0) ? "R9" : "R5";
      nrv = 1;
      nrk = m_hold_known && m_mem.exists(m_sp);
      nra = nrk ? ((m_hold << 8) | m_mem[m_sp]) : 0;
      nsp = (m_sp + 255) % 256;
    end else if (n > 1) begin
      tg = "R8";
    end else if (p) begin
      tg = (m_sp == 255) ? "R7" : "R2";
      x_we = 1; x_a = (m_sp + 1) % 256; x_d = pd;
      m_mem[x_a] = pd; nsp = x_a;
    end else if (q) begin
      tg = (m_sp == 0) ? "R7" : "R3";
      npv = 1; npk = m_mem.exists(m_sp); npd = npk ? m_mem[m_sp] : 0;
      nsp = (m_sp + 255) % 256;
    end else if (c) begin
      tg = "R4";
      x_we = 1; x_a = (m_sp + 1) % 256; x_d = ca[7:0];
      m_mem[x_a] = ca[7:0]; nsp = x_a; nhold = ca[15:8]; nhk = 1; nphase = 1;
    end else if (r) begin
      tg = "R5";
      nhk = m_mem.exists(m_sp); nhold = nhk ? m_mem[m_sp] : 0;
      nsp = (m_sp + 255) % 256; nphase = 2;
    end else if (l) begin
      tg = "R6"; nsp = lv;
    end else begin
      tg = "R9";
    end
    check(tg, "illegal", illegal, (m_phase == 0 && n > 1));
    check(tg, "ram_we", ram_we, x_we);
    if (x_we) begin
      check(tg, "ram_addr", ram_addr, x_a);
      check(tg, "ram_wdata", ram_wdata, x_d);
    end
    @(posedge clk);
    m_sp = nsp; m_phase = nphase; m_hold = nhold; m_hold_known = nhk;
    e_pv = npv; e_rv = nrv; e_pd = npd; e_ra = nra; e_pd_known = npk; e_ra_known = nrk;
    @(negedge clk);
    check(tg, "sp_out", sp_out, m_sp);
    check(tg, "busy", busy, (m_phase != 0));
    check(tg, "pop_valid", pop_valid, e_pv);
    check(tg, "ret_valid", ret_valid, e_rv);
    if (e_pv && e_pd_known) check(tg, "pop_data", pop_data, e_pd);
    if (e_rv && e_ra_known) check(tg, "ret_addr", ret_addr, e_ra);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    m_sp = 7; m_phase = 0; m_hold = 0; m_hold_known = 0;
    e_pv = 0; e_rv = 0; e_pd = 0; e_ra = 0; e_pd_known = 0; e_ra_known = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", "sp_out in reset", sp_out, 8'h07);
    check("R1", "busy in reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "sp_out", sp_out, 8'h07);
    check("R1", "pop_valid", pop_valid, 0);
    check("R1", "ret_valid", ret_valid, 0);
    check("R1", "illegal", illegal, 0);
    check("R1", "ram_we", ram_we, 0);
    // R2 first push lands at 0x08
    cycle(1, 8'hA5, 0, 0, 0, 0, 0, 0);
    check("R2", "first push sp", sp_out, 8'h08);
    cycle(1, 8'h3C, 0, 0, 0, 0, 0, 0);
    // R3 pops in reverse order
    cycle(0, 0, 1, 0, 0, 0, 0, 0);
    check("R3", "pop_data first", pop_data, 8'h3C);
    cycle(0, 0, 1, 0, 0, 0, 0, 0);
    check("R3", "pop_data second", pop_data, 8'hA5);
    idle();
    // R4 save, with stray strobes during the busy beat (R9)
    cycle(0, 0, 0, 1, 16'h1234, 0, 0, 0);
    cycle(1, 8'hEE, 1, 0, 0, 1, 1, 8'h99);
    check("R4", "sp after save", sp_out, 8'h09);
    // R5 restore
    cycle(0, 0, 0, 0, 0, 1, 0, 0);
    idle();
    check("R5", "ret_addr", ret_addr, 16'h1234);
    check("R5", "sp after restore", sp_out, 8'h07);
    // R6 load
    cycle(0, 0, 0, 0, 0, 0, 1, 8'h40);
    cycle(1, 8'h5A, 0, 0, 0, 0, 0, 0);
    check("R6", "push after load", sp_out, 8'h41);
    // R7 wrap both ways
    cycle(0, 0, 0, 0, 0, 0, 1, 8'hFF);
    cycle(1, 8'h77, 0, 0, 0, 0, 0, 0);
    check("R7", "sp wraps up", sp_out, 8'h00);
    cycle(0, 0, 1, 0, 0, 0, 0, 0);
    check("R7", "sp wraps down", sp_out, 8'hFF);
    check("R7", "pop_data at 0x00", pop_data, 8'h77);
    cycle(0, 0, 0, 1, 16'hBEEF, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1, 0, 0);
    idle();
    check("R7", "restore across wrap", ret_addr, 16'hBEEF);
    // R8 collisions
    cycle(1, 8'h11, 1, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 16'h4321, 0, 1, 8'h20);
    cycle(1, 8'h22, 1, 1, 16'h0, 1, 1, 8'h30);
    check("R8", "sp unchanged", sp_out, 8'hFF);
    // mixed run
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      bit [2:0] sel;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = lfsr[2:0];
      case (sel)
        3'd0: cycle(1, lfsr[15:8], 0, 0, 0, 0, 0, 0);
        3'd1: cycle(0, 0, 1, 0, 0, 0, 0, 0);
        3'd2: cycle(0, 0, 0, 1, lfsr ^ 16'h5A5A, 0, 0, 0);
        3'd3: cycle(0, 0, 0, 0, 0, 1, 0, 0);
        3'd4: cycle(0, 0, 0, 0, 0, 0, lfsr[9], lfsr[15:8]);
        3'd5: cycle(lfsr[3], lfsr[11:4], lfsr[4], lfsr[5], lfsr, lfsr[6], 0, 0);
        default: idle();
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule